// File: doc/BRIEF.md
# Adaptive Hold Logic Controller

This controller sits beside a variable-latency multiplier. For each operand presented on its multiplicand input it decides whether the product can settle in one clock cycle or needs two. The decision rests on how many zero bits the operand holds. Operands with many zeros take short paths through a bypassing array, so they are treated as one-cycle operations. Other operands are held in the input registers for an extra cycle. The controller drives a load enable for those registers. When the enable is low, the operand stays put and the datapath gets a second cycle.

Timing errors reported by an external error-detecting register force a one-cycle re-execution. They also feed an aging monitor. If too many errors arrive within a window of operations, the monitor raises a sticky aged flag. The controller then moves to a stricter zero-count threshold, so that fewer operands are trusted to finish in one cycle.

Top module: `ahl_ctrl`

## Requirements
- R1: After reset, `load_en` is 1 and `aged` is 0.
- R2: When `load_en` is 1, `err_pulse` is 0 and `aged` is 0, an operand with more than ZERO_THR zero bits (default 7 of 16) gives `load_en` = 1 in the next cycle.
- R3: When `load_en` is 1 and `err_pulse` is 0, an operand with ZERO_THR or fewer zero bits gives `load_en` = 0 in the next cycle. This holds whatever the value of `aged`.
- R4: A cycle with `load_en` = 0 and `err_pulse` = 0 is followed by `load_en` = 1, whatever the operand. A hold therefore never lasts more than one cycle.
- R5: While `aged` is 1, an operand needs more than ZERO_THR+1 zero bits (default 8) to be treated as one-cycle. An operand with exactly ZERO_THR+1 zeros gives `load_en` = 0 in the next cycle.
- R6: A cycle with `err_pulse` = 1 gives `load_en` = 0 in the next cycle, whatever the operand or the hold state. Unless another error follows, `load_en` returns to 1 one cycle later.
- R7: A load cycle is a clock edge at which `load_en` is 1. The error count restarts from zero after every WINDOW load cycles (default 256). `aged` becomes 1 in the cycle after the error that brings the count to ERR_LIMIT (default 4). An error that arrives on the closing load cycle of a window still counts toward that limit before the count restarts.
- R8: Once `aged` is 1, it stays 1 until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcand | input | WIDTH | Multiplicand currently presented to the datapath |
| err_pulse | input | 1 | Timing-error indication for the current result |
| load_en | output | 1 | 1: input registers take new operands at the next edge; 0: they hold |
| aged | output | 1 | Sticky flag: the error rate has shown aging |

## Verification
On every cycle, the assertions check the next-cycle effect of the port inputs on `load_en`: the error override, the one-cycle limit on a hold, and the short-operand hold under either threshold. They also check that `aged` never falls and rises only after an error. The exact boundary at which the threshold moves by one zero bit after aging, the count of errors per window, and the restart of that count after WINDOW load cycles need long scripted sequences. The bench's scenarios show these against its scoreboard model. The bench also covers the fresh-threshold acceptance and the clearing of `aged` by reset.

// File: rtl/ahl_pkg.sv
package ahl_pkg;
   // index of each judging block in the judgement vector
   typedef enum int {
      JUDGE_FRESH = 0,
      JUDGE_AGED  = 1
   } judge_idx_e;
   localparam int NUM_JUDGES = 2;
endpackage

// File: rtl/ahl_zero_judge.sv
module ahl_zero_judge #(
   parameter int WIDTH = 16,
   parameter int THR   = 7
) (
   input  logic [WIDTH-1:0] operand,
   output logic             pass
);
   localparam int ZW = $clog2(WIDTH + 1);

   logic [ZW-1:0] zeros;

   always_comb begin
      zeros = '0;
      for (int i = 0; i < WIDTH; i++) begin
         zeros = zeros + ZW'(~operand[i]);
      end
   end

   // one-cycle pattern when zero count strictly exceeds the threshold
   assign pass = (zeros > ZW'(THR));
endmodule

// File: rtl/ahl_hold_ctl.sv
module ahl_hold_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic one_cycle,
   input  logic err,
   output logic gate
);
   logic gate_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= 1'b1;
      end else begin
         // a hold ends after one cycle; an error always forces a hold
         gate_q <= (one_cycle | ~gate_q) & ~err;
      end
   end

   assign gate = gate_q;
endmodule

// File: rtl/ahl_aging_mon.sv
module ahl_aging_mon #(
   parameter int WINDOW    = 256,
   parameter int ERR_LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic op_load,
   input  logic err,
   output logic aged
);
   localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;

   logic [WIN_W-1:0] op_cnt;
   logic             win_end;
   logic             aged_q;
   logic             hit;

   assign win_end = op_load && (op_cnt == WIN_W'(WINDOW - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_cnt <= '0;
      end else if (op_load) begin
         op_cnt <= win_end ? '0 : op_cnt + 1'b1;
      end
   end

   generate
      if (ERR_LIMIT == 1) begin : g_single
         // the first error already reaches the limit
         assign hit = err;
      end else begin : g_count
         localparam int ECW = $clog2(ERR_LIMIT);
         logic [ECW-1:0] err_cnt;

         assign hit = err && (err_cnt == ECW'(ERR_LIMIT - 1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               err_cnt <= '0;
            end else if (win_end) begin
               err_cnt <= '0;
            end else if (err && (err_cnt != ECW'(ERR_LIMIT - 1))) begin
               err_cnt <= err_cnt + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aged_q <= 1'b0;
      end else if (hit) begin
         aged_q <= 1'b1;
      end
   end

   assign aged = aged_q;
endmodule

// File: rtl/ahl_ctrl.sv
module ahl_ctrl #(
   parameter int WIDTH     = 16,
   parameter int ZERO_THR  = 7,
   parameter int WINDOW    = 256,
   parameter int ERR_LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] mcand,
   input  logic             err_pulse,
   output logic             load_en,
   output logic             aged
);
   import ahl_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ahl_ctrl: WIDTH must be at least 2");
      end
      if (ZERO_THR < 0 || ZERO_THR + 1 >= WIDTH) begin : g_bad_thr
         $error("ahl_ctrl: ZERO_THR+1 must be below WIDTH");
      end
      if (WINDOW < 2) begin : g_bad_win
         $error("ahl_ctrl: WINDOW must be at least 2");
      end
      if (ERR_LIMIT < 1 || ERR_LIMIT > WINDOW) begin : g_bad_lim
         $error("ahl_ctrl: ERR_LIMIT must lie in 1..WINDOW");
      end
   endgenerate

   logic [NUM_JUDGES-1:0] judge;
   logic                  sel_judge;

   generate
      for (genvar g = 0; g < NUM_JUDGES; g++) begin : g_judge
         ahl_zero_judge #(
            .WIDTH(WIDTH),
            .THR  (ZERO_THR + g)
         ) u_judge (
            .operand(mcand),
            .pass   (judge[g])
         );
      end
   endgenerate

   assign sel_judge = aged ? judge[JUDGE_AGED] : judge[JUDGE_FRESH];

   ahl_hold_ctl u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .one_cycle(sel_judge),
      .err      (err_pulse),
      .gate     (load_en)
   );

   ahl_aging_mon #(
      .WINDOW   (WINDOW),
      .ERR_LIMIT(ERR_LIMIT)
   ) u_age (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_load(load_en),
      .err    (err_pulse),
      .aged   (aged)
   );
endmodule

// File: rtl/ahl_ctrl_chk.sv
module ahl_ctrl_chk #(
   parameter int WIDTH    = 16,
   parameter int ZERO_THR = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] mcand,
   input logic             err_pulse,
   input logic             load_en,
   input logic             aged
);
   int zc;
   assign zc = $countones(~mcand);

   assert_fresh_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !err_pulse && !aged && zc > ZERO_THR) |=> load_en);

   assert_short_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !err_pulse && zc <= ZERO_THR) |=> !load_en);

   assert_hold_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !err_pulse) |=> load_en);

   assert_aged_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !err_pulse && aged && zc <= ZERO_THR + 1) |=> !load_en);

   assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !load_en);

   assert_aged_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aged) |-> $past(err_pulse));

   assert_aged_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      aged |=> aged);
endmodule

bind ahl_ctrl ahl_ctrl_chk #(
   .WIDTH   (WIDTH),
   .ZERO_THR(ZERO_THR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mcand    (mcand),
   .err_pulse(err_pulse),
   .load_en  (load_en),
   .aged     (aged)
);

// File: tb/sim_ahl_ctrl.sv
module sim_ahl_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int W   = 16;
   localparam int THR = 7;
   localparam int WIN = 256;
   localparam int LIM = 4;

   typedef struct {
      logic  gate;
      logic  aged;
      string tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] mcand = '0;
   logic         err_pulse = 1'b0;
   logic         load_en;
   logic         aged;

   int   n_checks = 0;
   int   n_errors = 0;
   exp_t sb[$];

   // bench model state
   logic m_gate = 1'b1;
   logic m_aged = 1'b0;
   int   m_ecnt = 0;
   int   m_ocnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ahl_ctrl #(.WIDTH(W), .ZERO_THR(THR), .WINDOW(WIN), .ERR_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .mcand(mcand), .err_pulse(err_pulse),
      .load_en(load_en), .aged(aged)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_gate = 1'b1; m_aged = 1'b0; m_ecnt = 0; m_ocnt = 0;
   endtask

   // driver: present inputs, predict next-cycle outputs, push to scoreboard
   task automatic drive(input logic [W-1:0] m, input logic e, input string tag);
      exp_t it;
      int   zeros;
      int   lim;
      logic pass;
      logic wend;
      @(negedge clk);
      mcand = m;
      err_pulse = e;
      zeros = $countones(~m);
      lim = m_aged ? THR + 1 : THR;
      pass = zeros > lim;
      wend = m_gate && (m_ocnt == WIN - 1);
      it.gate = e ? 1'b0 : (!m_gate ? 1'b1 : pass);
      it.aged = m_aged || (e && m_ecnt == LIM - 1);
      it.tag = tag;
      sb.push_back(it);
      if (m_gate) m_ocnt = wend ? 0 : m_ocnt + 1;
      if (wend) m_ecnt = 0;
      else if (e && m_ecnt < LIM - 1) m_ecnt = m_ecnt + 1;
      m_aged = it.aged;
      m_gate = it.gate;
      @(posedge clk);
   endtask

   // monitor: compare after each edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         check({it.tag, " load_en"}, load_en, it.gate);
         check({it.tag, " aged"}, aged, it.aged);
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      #1;
      check("R1 reset load_en", load_en, 1'b1);
      check("R1 reset aged", aged, 1'b0);

      // R2: 16, 8 and 9 zero operands pass on a fresh circuit
      drive(16'h0000, 1'b0, "R2");
      drive(16'h00FF, 1'b0, "R2");
      drive(16'h007F, 1'b0, "R2");
      drive(16'hA0A0, 1'b0, "R2");
      // R3 with 0 and 7 zeros; R4 the hold then releases even for short operand
      drive(16'hFFFF, 1'b0, "R3");
      drive(16'hFFFF, 1'b0, "R4");
      drive(16'h01FF, 1'b0, "R3");
      drive(16'h01FF, 1'b0, "R4");
      drive(16'h5555, 1'b0, "R2");
      // R6 error overrides an accepting operand, and error during a hold
      drive(16'h0000, 1'b1, "R6");
      drive(16'h0000, 1'b0, "R6");
      drive(16'hFFFF, 1'b0, "R3");
      drive(16'hFFFF, 1'b1, "R6");
      drive(16'h0000, 1'b0, "R6");
      // two errors so far; fill past a window so the count restarts
      for (int i = 0; i < WIN + 40; i++) drive(16'h0000, 1'b0, "R7");
      drive(16'h0000, 1'b1, "R7");
      drive(16'h0000, 1'b0, "R7");
      drive(16'h0000, 1'b1, "R7");
      drive(16'h0000, 1'b0, "R7");
      drive(16'h0000, 1'b1, "R7");
      drive(16'h0000, 1'b0, "R7");
      // fourth error in window sets aged
      drive(16'h0000, 1'b1, "R7");
      drive(16'h0000, 1'b0, "R7");
      // R5: 8 zeros now holds, 9 zeros passes
      drive(16'h00FF, 1'b0, "R5");
      drive(16'h00FF, 1'b0, "R4");
      drive(16'h007F, 1'b0, "R5");
      drive(16'h00FF, 1'b0, "R5");
      drive(16'h0000, 1'b0, "R5");
      // R8 stays set over many cycles without errors
      for (int i = 0; i < 20; i++) drive(16'h0000, 1'b0, "R8");
      // R8 reset clears it
      @(negedge clk);
      rst_n = 1'b0;
      mcand = '0;
      err_pulse = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      #1;
      check("R8 aged after reset", aged, 1'b0);
      check("R1 load_en after reset", load_en, 1'b1);
      drive(16'h00FF, 1'b0, "R8");
      repeat (3) @(posedge clk);
      #2;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule